// File: doc/BRIEF.md
# Interrupt Vector Routing Unit

The unit takes six level-sensitive interrupt inputs and maps each one onto one of six output lines. Each input owns a vector register that carries a target server number, a priority, a source number that picks the output line, and a pending flag. The source number decides which output line an asserted input raises. A priority of all ones masks the input. The pending flag shows whether the input is asserted and unmasked.

The first input shares its line with a second cause, `aux_in`, and that line stays high until both causes have dropped. Status for all inputs can be read back through a small register port. Every accepted vector write also refreshes the server and priority values delivered to a downstream presentation controller. The server value is delivered with its two low link bits removed. Writes that name a source outside the six lines are kept in the register, but they leave the routing and the delivered values untouched.

Top module: `ivr_router`

## Requirements
- R1: After reset, vector register i reads priority 0xFF (bits 39:32), source number i (bits 31:29), server 0 and pending 0. All output lines are low, the delivered priorities are 0xFF and the delivered servers are 0.
- R2: A write to vector register i (address i, 0..5) stores only the server (bits 55:40), priority (bits 39:32) and source (bits 31:29) fields. All other bits read back as zero, except pending at bit 24. Read data appears on `cfg_rdata` in the cycle after `cfg_rd`.
- R3: An asserted input sets its status bit. Input 0 reports at bit 46 of the control word (address 6). Inputs 1, 2, 3, 4 and 5 report at bits 36, 35, 34, 33 and 32 of the status word (address 7).
- R4: An asserted input raises the output line given by its current route. Several inputs routed to the same line are ORed together.
- R5: `aux_in` reports at bit 47 of the control word and drives the same line as input 0. That line stays high while either cause is set.
- R6: The pending bit (bit 24) is 1 exactly when the input's effective asserted state is 1 and its priority is not 0xFF. A write of priority 0xFF clears it at once.
- R7: A write whose source value is below 6 moves the route to that line. It also updates the delivered priority and the delivered server, which is the server field shifted right by 2 (14 bits).
- R8: A write whose source value is 6 or 7 still stores the fields. The route, the delivered server and the delivered priority keep their previous values.
- R9: Addresses 8 to 15 read as all ones. Writes to the control and status addresses change nothing.
- R10: An input change reaches `line_out` on the fourth rising edge after it is applied. The path is two synchroniser flops, a status flop and the line register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 6 | Level interrupt inputs |
| aux_in | input | 1 | Second cause sharing input 0's line |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Registered read data |
| line_out | output | 6 | Registered interrupt output lines |
| tgt_server | output | 84 | Delivered server per input, 14 bits each |
| tgt_prio | output | 48 | Delivered priority per input, 8 bits each |

## Verification
Single inputs on their reset routes confirm the identity mapping, the status bit positions and the exact four-edge latency. Two inputs steered onto one line, and input 0 overlapping with `aux_in`, separate a correct OR-and-hold from a design that drops the line when the first cause clears. Mask, unmask and re-mask writes with the input held high expose any pending bit that lags the priority. A write with an out-of-range source shows whether the stored fields and the live routing are kept apart.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int REG_W   = 64;
  localparam int SRV_LSB = 40;
  localparam int SRV_W   = 16;
  localparam int PRI_LSB = 32;
  localparam int PRI_W   = 8;
  localparam int SRC_LSB = 29;
  localparam int SRC_W   = 3;
  localparam int PND_BIT = 24;
  localparam int LINK_W  = 2;
  localparam int DSRV_W  = SRV_W - LINK_W;
  localparam int CTRL_PRIMARY_BIT = 46;
  localparam int CTRL_SHARED_BIT  = 47;
  localparam int STAT_TOP_BIT     = 37;
  localparam logic [PRI_W-1:0] PRI_MASKED = '1;
endpackage

// File: rtl/ivr_sync.sv
module ivr_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/ivr_vector.sv
module ivr_vector
  import ivr_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter int IDX   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              active,
  output logic [REG_W-1:0]  rdata,
  output logic [SRC_W-1:0]  route,
  output logic [DSRV_W-1:0] srv_out,
  output logic [PRI_W-1:0]  pri_out
);
  localparam logic [SRC_W-1:0] RESET_SRC = SRC_W'(IDX);
  localparam logic [SRC_W:0]   SRC_LIMIT = (SRC_W+1)'(N_SRC);

  logic [SRV_W-1:0] wsrv, srv_q;
  logic [PRI_W-1:0] wpri, pri_q, pri_next;
  logic [SRC_W-1:0] wsrc, src_q;
  logic             pend_q, accept;
  logic             unused_wbits;

  assign wsrv = wdata[SRV_LSB +: SRV_W];
  assign wpri = wdata[PRI_LSB +: PRI_W];
  assign wsrc = wdata[SRC_LSB +: SRC_W];
  assign unused_wbits = ^{wdata[REG_W-1:SRV_LSB+SRV_W], wdata[SRC_LSB-1:0]};
  assign accept   = {1'b0, wsrc} < SRC_LIMIT;
  assign pri_next = wr_en ? wpri : pri_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      srv_q   <= '0;
      pri_q   <= PRI_MASKED;
      src_q   <= RESET_SRC;
      pend_q  <= 1'b0;
      route   <= RESET_SRC;
      srv_out <= '0;
      pri_out <= PRI_MASKED;
    end else begin
      pend_q <= active && (pri_next != PRI_MASKED);
      if (wr_en) begin
        srv_q <= wsrv;
        pri_q <= wpri;
        src_q <= wsrc;
        if (accept) begin
          route   <= wsrc;
          srv_out <= wsrv[SRV_W-1:LINK_W];
          pri_out <= wpri;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    rdata[SRV_LSB +: SRV_W] = srv_q;
    rdata[PRI_LSB +: PRI_W] = pri_q;
    rdata[SRC_LSB +: SRC_W] = src_q;
    rdata[PND_BIT]          = pend_q;
  end

  // R6
  mask_blocks_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (pri_q == PRI_MASKED && !wr_en) |=> !pend_q);

  // R8
  reject_keeps_route_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !accept) |=> ($stable(route) && $stable(pri_out) && $stable(srv_out)));

  // R7
  accept_moves_route_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && accept) |=> (route == $past(wsrc)));
endmodule

// File: rtl/ivr_line_map.sv
module ivr_line_map
  import ivr_pkg::*;
#(
  parameter int N_SRC = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC*SRC_W-1:0] route_all,
  input  logic [N_SRC-1:0]       active,
  output logic [N_SRC-1:0]       line_q
);
  logic [N_SRC-1:0] hit;

  always_comb begin
    hit = '0;
    for (int i = 0; i < N_SRC; i++) begin
      for (int k = 0; k < N_SRC; k++) begin
        if (active[i] && route_all[i*SRC_W +: SRC_W] == SRC_W'(k)) hit[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= hit;
  end
endmodule

// File: rtl/ivr_router.sv
module ivr_router
  import ivr_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC-1:0]        irq_in,
  input  logic                    aux_in,
  input  logic                    cfg_wr,
  input  logic                    cfg_rd,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [REG_W-1:0]        cfg_wdata,
  output logic [REG_W-1:0]        cfg_rdata,
  output logic [N_SRC-1:0]        line_out,
  output logic [N_SRC*DSRV_W-1:0] tgt_server,
  output logic [N_SRC*PRI_W-1:0]  tgt_prio
);
  localparam int CTRL_IDX = N_SRC;
  localparam int STAT_IDX = N_SRC + 1;

  logic [N_SRC:0]           sync_q;
  logic [N_SRC-1:0]         status_q;
  logic                     aux_q;
  logic [N_SRC-1:0]         eff;
  logic [N_SRC*SRC_W-1:0]   route_all;
  logic [REG_W-1:0]         vec_rd [N_SRC];
  logic [REG_W-1:0]         ctrl_word, stat_word, rd_mux;

  ivr_sync #(.W(N_SRC+1)) u_sync (
    .clk(clk), .rst(rst), .d({aux_in, irq_in}), .q(sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      aux_q    <= 1'b0;
    end else begin
      status_q <= sync_q[N_SRC-1:0];
      aux_q    <= sync_q[N_SRC];
    end
  end

  always_comb begin
    eff    = status_q;
    eff[0] = status_q[0] | aux_q;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_vec
    logic [SRC_W-1:0] route_i;
    ivr_vector #(.N_SRC(N_SRC), .IDX(i)) u_vec (
      .clk(clk), .rst(rst),
      .wr_en(cfg_wr && cfg_addr == ADDR_W'(i)),
      .wdata(cfg_wdata), .active(eff[i]),
      .rdata(vec_rd[i]), .route(route_i),
      .srv_out(tgt_server[i*DSRV_W +: DSRV_W]),
      .pri_out(tgt_prio[i*PRI_W +: PRI_W])
    );
    assign route_all[i*SRC_W +: SRC_W] = route_i;
  end

  ivr_line_map #(.N_SRC(N_SRC)) u_map (
    .clk(clk), .rst(rst), .route_all(route_all), .active(eff), .line_q(line_out)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_PRIMARY_BIT] = status_q[0];
    ctrl_word[CTRL_SHARED_BIT]  = aux_q;
    stat_word = '0;
    for (int i = 1; i < N_SRC; i++) stat_word[STAT_TOP_BIT-i] = status_q[i];
    rd_mux = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (cfg_addr == ADDR_W'(i)) rd_mux = vec_rd[i];
    end
    if (cfg_addr == ADDR_W'(CTRL_IDX)) rd_mux = ctrl_word;
    if (cfg_addr == ADDR_W'(STAT_IDX)) rd_mux = stat_word;
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  // R5
  shared_line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_q[0] || aux_q) && route_all[SRC_W-1:0] == '0) |=> line_out[0]);

  // R10
  status_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[0]) |-> $past(sync_q[0]));
endmodule

// File: tb/ivr_router_bench.sv
module ivr_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  irq_in = '0;
  logic        aux_in = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic [5:0]  line_out;
  logic [83:0] tgt_server;
  logic [47:0] tgt_prio;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ivr_router u_ivr_router (
    .clk(clk), .rst(rst), .irq_in(irq_in), .aux_in(aux_in),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .line_out(line_out),
    .tgt_server(tgt_server), .tgt_prio(tgt_prio)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] vec(input logic [15:0] s, input logic [7:0] p,
                                      input logic [2:0] src, input logic pnd);
    return ({48'b0, s} << 40) | ({56'b0, p} << 32) | ({61'b0, src} << 29) | ({63'b0, pnd} << 24);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk); cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_rd = 1'b0; d = cfg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    for (int i = 0; i < 6; i++) begin
      rd(4'(i), d);
      chk("R1 vector reset", d, vec(16'h0, 8'hFF, 3'(i), 1'b0));
    end
    chk("R1 lines low", {58'b0, line_out}, 64'h0);
    chk("R1 delivered prio", {16'b0, tgt_prio}, {16'b0, {6{8'hFF}}});
    chk("R1 delivered server", tgt_server[63:0], 64'h0);
  endtask

  task automatic t_latency_status();
    logic [63:0] d;
    @(negedge clk); irq_in[3] = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R10 line not yet", {58'b0, line_out}, 64'h0);
    @(posedge clk); @(negedge clk);
    chk("R10 R4 line 3 up", {58'b0, line_out}, 64'h8);
    rd(4'd7, d);
    chk("R3 status bit 34", d, 64'h1 << 34);
    rd(4'd3, d);
    chk("R6 masked no pending", d, vec(16'h0, 8'hFF, 3'd3, 1'b0));
    @(negedge clk); irq_in[3] = 1'b0; irq_in[1] = 1'b1; irq_in[5] = 1'b1;
    settle();
    rd(4'd7, d);
    chk("R3 status bits 36 and 32", d, (64'h1 << 36) | (64'h1 << 32));
    chk("R4 lines 1 and 5", {58'b0, line_out}, 64'h22);
    @(negedge clk); irq_in = '0;
    settle();
    chk("R4 lines clear", {58'b0, line_out}, 64'h0);
  endtask

  task automatic t_pending();
    logic [63:0] d;
    wr(4'd2, vec(16'h1234, 8'h05, 3'd2, 1'b0));
    chk("R7 server shifted", {50'b0, tgt_server[2*14 +: 14]}, 64'h48D);
    chk("R7 prio delivered", {56'b0, tgt_prio[2*8 +: 8]}, 64'h05);
    @(negedge clk); irq_in[2] = 1'b1;
    settle();
    rd(4'd2, d);
    chk("R6 pending set", d, vec(16'h1234, 8'h05, 3'd2, 1'b1));
    wr(4'd2, vec(16'h1234, 8'hFF, 3'd2, 1'b0));
    rd(4'd2, d);
    chk("R6 mask clears pending", d, vec(16'h1234, 8'hFF, 3'd2, 1'b0));
    wr(4'd2, vec(16'h1234, 8'h05, 3'd2, 1'b0));
    rd(4'd2, d);
    chk("R6 unmask sets pending", d, vec(16'h1234, 8'h05, 3'd2, 1'b1));
    @(negedge clk); irq_in[2] = 1'b0;
    settle();
    rd(4'd2, d);
    chk("R6 drop clears pending", d, vec(16'h1234, 8'h05, 3'd2, 1'b0));
  endtask

  task automatic t_shared();
    logic [63:0] d;
    @(negedge clk); irq_in[0] = 1'b1;
    settle();
    rd(4'd6, d);
    chk("R3 control bit 46", d, 64'h1 << 46);
    @(negedge clk); aux_in = 1'b1;
    settle();
    rd(4'd6, d);
    chk("R5 control bits 46 47", d, (64'h1 << 46) | (64'h1 << 47));
    @(negedge clk); irq_in[0] = 1'b0;
    settle();
    chk("R5 line 0 held by aux", {58'b0, line_out}, 64'h1);
    @(negedge clk); aux_in = 1'b0;
    settle();
    chk("R5 line 0 released", {58'b0, line_out}, 64'h0);
  endtask

  task automatic t_reroute();
    @(negedge clk); wr(4'd4, vec(16'h0, 8'h20, 3'd1, 1'b0));
    @(negedge clk); irq_in[4] = 1'b1; irq_in[1] = 1'b1;
    settle();
    chk("R7 R4 input 4 on line 1", {58'b0, line_out}, 64'h2);
    @(negedge clk); irq_in[1] = 1'b0;
    settle();
    chk("R4 line 1 held by input 4", {58'b0, line_out}, 64'h2);
    @(negedge clk); irq_in[4] = 1'b0;
    settle();
    chk("R4 line 1 clear", {58'b0, line_out}, 64'h0);
  endtask

  task automatic t_reject();
    logic [63:0] d;
    wr(4'd5, vec(16'hFFFF, 8'h33, 3'd7, 1'b0));
    rd(4'd5, d);
    chk("R8 fields stored", d, vec(16'hFFFF, 8'h33, 3'd7, 1'b0));
    chk("R8 prio kept", {56'b0, tgt_prio[5*8 +: 8]}, 64'hFF);
    chk("R8 server kept", {50'b0, tgt_server[5*14 +: 14]}, 64'h0);
    @(negedge clk); irq_in[5] = 1'b1;
    settle();
    chk("R8 old route", {58'b0, line_out}, 64'h20);
    @(negedge clk); irq_in[5] = 1'b0;
    settle();
  endtask

  task automatic t_map_edges();
    logic [63:0] d;
    rd(4'd8, d);
    chk("R9 addr 8 ones", d, '1);
    rd(4'd15, d);
    chk("R9 addr 15 ones", d, '1);
    wr(4'd7, '1);
    wr(4'd6, '1);
    rd(4'd7, d);
    chk("R9 status unwritable", d, 64'h0);
    rd(4'd6, d);
    chk("R9 control unwritable", d, 64'h0);
    wr(4'd3, 64'hFFFF_FFFF_5FFF_FFFF);
    rd(4'd3, d);
    chk("R2 only fields kept", d, 64'h00FF_FFFF_4000_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_latency_status();
    t_pending();
    t_shared();
    t_reroute();
    t_reject();
    t_map_edges();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule